// File: doc/BRIEF.md
# Index Register Execution Unit

This unit executes the index-register instructions of a 36-bit word machine. It holds sixty-four signed 18-bit index registers, and entry zero of the bank is a constant zero. The unit receives an instruction that is already decoded: an operation code, a six-bit register number j, a five-bit configuration field, an 18-bit operand field and a hold bit. With it come the memory word that was already read, a flag saying that read failed, and the current program counter. Address resolution, indirection and memory access take place outside the unit.

The unit can load a register from the right half of a memory word, add that half to a register, set a register from the operand field, and deposit a register into memory with sign extension. It also has two counting branches that test the register and then step it by the signed configuration field. Each result appears one clock after the instruction is presented, as one registered set of pulses:

- a memory write strobe and its data,
- a jump request with its target,
- a new value for the right half of the E register,
- a dismiss pulse for the running sequence,
- a flag-raise pulse with its sequence number,
- a two-bit alarm code.

The register bank updates on the same edge. An instruction presented on the very next cycle therefore sees the new value.

Top module: `idx_exec_unit`

## Requirements
- R1: Each cycle with `in_valid` high gives exactly one `out_done` pulse on the following cycle, and no other cycle shows `out_done`. After reset, every output is zero. Operation codes 6 and 7 complete with every other output zero.
- R2: Register number 0 always reads as zero. A load, add or set aimed at it leaves it zero.
- R3: Operation code 0 (load) sets Xj to bits 17:0 of `in_mem_word`.
- R4: Operation code 1 (add) sets Xj to Xj plus bits 17:0 of `in_mem_word`, modulo 2^18.
- R5: Operation code 2 (set) with configuration 0 sets Xj to `in_operand`. With configuration 1 it sets Xj to the two's complement negation of `in_operand`.
- R6: Operation code 2 with configuration 8 sets Xj to `in_operand` and pulses `out_flag_raise`, with `out_flag_seq` equal to j.
- R7: Operation code 2 with any configuration other than 0, 1 or 8 gives alarm code 1 and leaves Xj unchanged.
- R8: Operation code 3 (deposit) pulses `out_mem_we`. Its `out_mem_wdata` is Xj sign-extended to 36 bits.
- R9: Operation code 3 with `in_mem_fault` high gives alarm code 2 and no memory write.
- R10: Operation code 4 jumps when Xj, before its update, is nonzero with bit 17 clear. Operation code 5 jumps when bit 17 of Xj, before its update, is set.
- R11: Operation codes 4 and 5 always replace Xj with Xj plus the sign-extended configuration field, modulo 2^18. There is no update when j is 0.
- R12: A taken jump pulses `out_jump` with `out_jump_target` equal to `in_operand`, and pulses `out_e_load` with `out_e_right` equal to `in_pc`. When the hold bit is clear it also pulses `out_dismiss`.
- R13: In a cycle with a nonzero alarm there is no jump, no memory write, no flag pulse and no register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Operation code |
| in_idx | input | 6 | Index register number j |
| in_cfg | input | 5 | Configuration field |
| in_operand | input | 18 | Operand field, also the jump target |
| in_hold | input | 1 | Hold bit |
| in_mem_word | input | 36 | Memory word already fetched |
| in_mem_fault | input | 1 | Memory read for a deposit failed |
| in_pc | input | 18 | Current program counter |
| out_done | output | 1 | Instruction completed |
| out_mem_we | output | 1 | Memory write strobe |
| out_mem_wdata | output | 36 | Memory write data |
| out_jump | output | 1 | Jump request |
| out_jump_target | output | 18 | Jump target |
| out_e_load | output | 1 | Load right half of E |
| out_e_right | output | 18 | New right half of E |
| out_dismiss | output | 1 | Dismiss the running sequence |
| out_flag_raise | output | 1 | Raise a sequence flag |
| out_flag_seq | output | 6 | Sequence whose flag is raised |
| out_alarm | output | 2 | 0 none, 1 unimplemented configuration, 2 memory write fault |

## Verification
The assertions assume that `in_valid` stays low until the internal reset synchronizer has released. They also assume that the input fields are stable and defined whenever `in_valid` is high. The bench follows both rules: it waits several clocks after reset before it issues anything, and it changes inputs only on falling edges. It reads register contents back through deposit instructions, so it needs no internal probing.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int HALF_BITS = 18;
  localparam int IDX_BITS  = 6;
  localparam int CFG_BITS  = 5;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SET   = 3'd2,
    OP_STORE = 3'd3,
    OP_JPOS  = 3'd4,
    OP_JNEG  = 3'd5,
    OP_NOP6  = 3'd6,
    OP_NOP7  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ALM_NONE   = 2'd0,
    ALM_UNIMPL = 2'd1,
    ALM_WFAULT = 2'd2
  } alarm_e;

  localparam logic [CFG_BITS-1:0] SET_PLAIN  = 5'd0;
  localparam logic [CFG_BITS-1:0] SET_NEGATE = 5'd1;
  localparam logic [CFG_BITS-1:0] SET_FLAG   = 5'd8;
endpackage

// File: rtl/idx_rst_sync.sv
module idx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/idx_regfile.sv
module idx_regfile #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] rows;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign rows[g] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] row_q;
      logic              row_ce;
      assign row_ce = wr_en && (wr_addr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      row_q <= '0;
        else if (row_ce) row_q <= wr_data;
      end
      assign rows[g] = row_q;
    end
  end

  assign rd_data = rows[rd_addr];
endmodule

// File: rtl/idx_alu.sv
module idx_alu
  import idx_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int IDX_W  = 6,
  parameter int CFG_W  = 5
) (
  input  op_e                 op,
  input  logic [IDX_W-1:0]    idx,
  input  logic [CFG_W-1:0]    cfg,
  input  logic [HALF_W-1:0]   operand,
  input  logic                hold,
  input  logic [2*HALF_W-1:0] mem_word,
  input  logic                mem_fault,
  input  logic [HALF_W-1:0]   pc,
  input  logic [HALF_W-1:0]   xj,
  output logic                wr_en,
  output logic [HALF_W-1:0]   wr_val,
  output logic                mem_we,
  output logic [2*HALF_W-1:0] mem_wdata,
  output logic                jump,
  output logic [HALF_W-1:0]   jump_target,
  output logic                e_load,
  output logic [HALF_W-1:0]   e_right,
  output logic                dismiss,
  output logic                flag_raise,
  output logic [IDX_W-1:0]    flag_seq,
  output alarm_e              alarm
);
  localparam int EXT_W = HALF_W - CFG_W;

  logic [HALF_W-1:0] right_half;
  logic [HALF_W-1:0] cfg_ext;
  logic [HALF_W-1:0] stepped;
  logic              is_neg;
  logic              is_pos;
  logic              take;
  logic              idx_live;

  assign right_half = mem_word[HALF_W-1:0];
  assign cfg_ext    = {{EXT_W{cfg[CFG_W-1]}}, cfg};
  assign stepped    = xj + cfg_ext;
  assign is_neg     = xj[HALF_W-1];
  assign is_pos     = !is_neg && (xj != '0);
  assign idx_live   = (idx != '0);

  always_comb begin
    wr_en       = 1'b0;
    wr_val      = '0;
    mem_we      = 1'b0;
    mem_wdata   = '0;
    jump        = 1'b0;
    jump_target = '0;
    e_load      = 1'b0;
    e_right     = '0;
    dismiss     = 1'b0;
    flag_raise  = 1'b0;
    flag_seq    = '0;
    alarm       = ALM_NONE;
    take        = 1'b0;
    unique case (op)
      OP_LOAD: begin
        wr_en  = idx_live;
        wr_val = right_half;
      end
      OP_ADD: begin
        wr_en  = idx_live;
        wr_val = xj + right_half;
      end
      OP_SET: begin
        if (cfg == SET_PLAIN || cfg == SET_FLAG) begin
          wr_en  = idx_live;
          wr_val = operand;
          if (cfg == SET_FLAG) begin
            flag_raise = 1'b1;
            flag_seq   = idx;
          end
        end else if (cfg == SET_NEGATE) begin
          wr_en  = idx_live;
          wr_val = '0 - operand;
        end else begin
          alarm = ALM_UNIMPL;
        end
      end
      OP_STORE: begin
        if (mem_fault) begin
          alarm = ALM_WFAULT;
        end else begin
          mem_we    = 1'b1;
          mem_wdata = {{HALF_W{xj[HALF_W-1]}}, xj};
        end
      end
      OP_JPOS, OP_JNEG: begin
        take   = (op == OP_JPOS) ? is_pos : is_neg;
        wr_en  = idx_live;
        wr_val = stepped;
        if (take) begin
          jump        = 1'b1;
          jump_target = operand;
          e_load      = 1'b1;
          e_right     = pc;
          dismiss     = !hold;
        end
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/idx_out_stage.sv
module idx_out_stage
  import idx_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic                mem_we_d,
  input  logic [2*HALF_W-1:0] mem_wdata_d,
  input  logic                jump_d,
  input  logic [HALF_W-1:0]   jump_target_d,
  input  logic                e_load_d,
  input  logic [HALF_W-1:0]   e_right_d,
  input  logic                dismiss_d,
  input  logic                flag_raise_d,
  input  logic [IDX_W-1:0]    flag_seq_d,
  input  alarm_e              alarm_d,
  output logic                done_q,
  output logic                mem_we_q,
  output logic [2*HALF_W-1:0] mem_wdata_q,
  output logic                jump_q,
  output logic [HALF_W-1:0]   jump_target_q,
  output logic                e_load_q,
  output logic [HALF_W-1:0]   e_right_q,
  output logic                dismiss_q,
  output logic                flag_raise_q,
  output logic [IDX_W-1:0]    flag_seq_q,
  output logic [1:0]          alarm_q
);
  logic                done_n;
  logic                mem_we_n;
  logic [2*HALF_W-1:0] mem_wdata_n;
  logic                jump_n;
  logic [HALF_W-1:0]   jump_target_n;
  logic                e_load_n;
  logic [HALF_W-1:0]   e_right_n;
  logic                dismiss_n;
  logic                flag_raise_n;
  logic [IDX_W-1:0]    flag_seq_n;
  logic [1:0]          alarm_n;
  logic                stage_ce;

  assign stage_ce = valid || done_q;

  always_comb begin
    done_n        = valid;
    mem_we_n      = valid && mem_we_d;
    mem_wdata_n   = valid ? mem_wdata_d : '0;
    jump_n        = valid && jump_d;
    jump_target_n = valid ? jump_target_d : '0;
    e_load_n      = valid && e_load_d;
    e_right_n     = valid ? e_right_d : '0;
    dismiss_n     = valid && dismiss_d;
    flag_raise_n  = valid && flag_raise_d;
    flag_seq_n    = valid ? flag_seq_d : '0;
    alarm_n       = valid ? 2'(alarm_d) : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q        <= 1'b0;
      mem_we_q      <= 1'b0;
      mem_wdata_q   <= '0;
      jump_q        <= 1'b0;
      jump_target_q <= '0;
      e_load_q      <= 1'b0;
      e_right_q     <= '0;
      dismiss_q     <= 1'b0;
      flag_raise_q  <= 1'b0;
      flag_seq_q    <= '0;
      alarm_q       <= 2'd0;
    end else if (stage_ce) begin
      done_q        <= done_n;
      mem_we_q      <= mem_we_n;
      mem_wdata_q   <= mem_wdata_n;
      jump_q        <= jump_n;
      jump_target_q <= jump_target_n;
      e_load_q      <= e_load_n;
      e_right_q     <= e_right_n;
      dismiss_q     <= dismiss_n;
      flag_raise_q  <= flag_raise_n;
      flag_seq_q    <= flag_seq_n;
      alarm_q       <= alarm_n;
    end
  end
endmodule

// File: rtl/idx_exec_unit.sv
module idx_exec_unit
  import idx_pkg::*;
#(
  parameter int HALF_W      = idx_pkg::HALF_BITS,
  parameter int IDX_W       = idx_pkg::IDX_BITS,
  parameter int CFG_W       = idx_pkg::CFG_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_op,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic [CFG_W-1:0]    in_cfg,
  input  logic [HALF_W-1:0]   in_operand,
  input  logic                in_hold,
  input  logic [2*HALF_W-1:0] in_mem_word,
  input  logic                in_mem_fault,
  input  logic [HALF_W-1:0]   in_pc,
  output logic                out_done,
  output logic                out_mem_we,
  output logic [2*HALF_W-1:0] out_mem_wdata,
  output logic                out_jump,
  output logic [HALF_W-1:0]   out_jump_target,
  output logic                out_e_load,
  output logic [HALF_W-1:0]   out_e_right,
  output logic                out_dismiss,
  output logic                out_flag_raise,
  output logic [IDX_W-1:0]    out_flag_seq,
  output logic [1:0]          out_alarm
);
  logic                rst_int_n;
  logic [HALF_W-1:0]   xj;
  logic                alu_wr_en;
  logic [HALF_W-1:0]   alu_wr_val;
  logic                alu_mem_we;
  logic [2*HALF_W-1:0] alu_mem_wdata;
  logic                alu_jump;
  logic [HALF_W-1:0]   alu_jump_target;
  logic                alu_e_load;
  logic [HALF_W-1:0]   alu_e_right;
  logic                alu_dismiss;
  logic                alu_flag_raise;
  logic [IDX_W-1:0]    alu_flag_seq;
  alarm_e              alu_alarm;
  logic                rf_we;

  idx_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign rf_we = in_valid && alu_wr_en && (alu_alarm == ALM_NONE);

  idx_regfile #(.DATA_W(HALF_W), .ADDR_W(IDX_W)) i_regfile (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_addr (in_idx),
    .rd_data (xj),
    .wr_en   (rf_we),
    .wr_addr (in_idx),
    .wr_data (alu_wr_val)
  );

  idx_alu #(.HALF_W(HALF_W), .IDX_W(IDX_W), .CFG_W(CFG_W)) i_alu (
    .op          (op_e'(in_op)),
    .idx         (in_idx),
    .cfg         (in_cfg),
    .operand     (in_operand),
    .hold        (in_hold),
    .mem_word    (in_mem_word),
    .mem_fault   (in_mem_fault),
    .pc          (in_pc),
    .xj          (xj),
    .wr_en       (alu_wr_en),
    .wr_val      (alu_wr_val),
    .mem_we      (alu_mem_we),
    .mem_wdata   (alu_mem_wdata),
    .jump        (alu_jump),
    .jump_target (alu_jump_target),
    .e_load      (alu_e_load),
    .e_right     (alu_e_right),
    .dismiss     (alu_dismiss),
    .flag_raise  (alu_flag_raise),
    .flag_seq    (alu_flag_seq),
    .alarm       (alu_alarm)
  );

  idx_out_stage #(.HALF_W(HALF_W), .IDX_W(IDX_W)) i_out (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .valid         (in_valid),
    .mem_we_d      (alu_mem_we),
    .mem_wdata_d   (alu_mem_wdata),
    .jump_d        (alu_jump),
    .jump_target_d (alu_jump_target),
    .e_load_d      (alu_e_load),
    .e_right_d     (alu_e_right),
    .dismiss_d     (alu_dismiss),
    .flag_raise_d  (alu_flag_raise),
    .flag_seq_d    (alu_flag_seq),
    .alarm_d       (alu_alarm),
    .done_q        (out_done),
    .mem_we_q      (out_mem_we),
    .mem_wdata_q   (out_mem_wdata),
    .jump_q        (out_jump),
    .jump_target_q (out_jump_target),
    .e_load_q      (out_e_load),
    .e_right_q     (out_e_right),
    .dismiss_q     (out_dismiss),
    .flag_raise_q  (out_flag_raise),
    .flag_seq_q    (out_flag_seq),
    .alarm_q       (out_alarm)
  );
endmodule

// File: rtl/idx_exec_chk.sv
module idx_exec_chk #(
  parameter int HALF_W      = 18,
  parameter int IDX_W       = 6,
  parameter int CFG_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          in_op,
  input logic [IDX_W-1:0]    in_idx,
  input logic [CFG_W-1:0]    in_cfg,
  input logic [HALF_W-1:0]   in_operand,
  input logic                in_hold,
  input logic [2*HALF_W-1:0] in_mem_word,
  input logic                in_mem_fault,
  input logic [HALF_W-1:0]   in_pc,
  input logic                out_done,
  input logic                out_mem_we,
  input logic [2*HALF_W-1:0] out_mem_wdata,
  input logic                out_jump,
  input logic [HALF_W-1:0]   out_jump_target,
  input logic                out_e_load,
  input logic [HALF_W-1:0]   out_e_right,
  input logic                out_dismiss,
  input logic                out_flag_raise,
  input logic [IDX_W-1:0]    out_flag_seq,
  input logic [1:0]          out_alarm
);
  // R1
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);

  // R1
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);

  // R13
  alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_alarm != 2'd0) |-> (!out_jump && !out_mem_we && !out_flag_raise));

  // R12
  dismiss_needs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dismiss |-> (out_jump && out_e_load));

  // R12
  pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_jump |-> (out_e_right == $past(in_pc) && out_jump_target == $past(in_operand)));

  // R8
  deposit_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mem_we |-> (out_mem_wdata[2*HALF_W-1:HALF_W] == {HALF_W{out_mem_wdata[HALF_W-1]}}));

  // R10
  jump_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_jump |-> ($past(in_op) == 3'd4 || $past(in_op) == 3'd5));

  // R6
  flag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_raise |-> (out_flag_seq == $past(in_idx)));

  // R7
  unimpl_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2 && in_cfg != 5'd0 && in_cfg != 5'd1 && in_cfg != 5'd8)
      |=> (out_alarm == 2'd1));

  // R9
  wfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd3 && in_mem_fault) |=> (out_alarm == 2'd2 && !out_mem_we));
endmodule

bind idx_exec_unit idx_exec_chk #(
  .HALF_W(HALF_W), .IDX_W(IDX_W), .CFG_W(CFG_W), .SYNC_STAGES(SYNC_STAGES)
) i_chk (.*);

// File: tb/test_idx_exec_unit.sv
module test_idx_exec_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [5:0]  in_idx;
  logic [4:0]  in_cfg;
  logic [17:0] in_operand;
  logic        in_hold;
  logic [35:0] in_mem_word;
  logic        in_mem_fault;
  logic [17:0] in_pc;
  logic        out_done;
  logic        out_mem_we;
  logic [35:0] out_mem_wdata;
  logic        out_jump;
  logic [17:0] out_jump_target;
  logic        out_e_load;
  logic [17:0] out_e_right;
  logic        out_dismiss;
  logic        out_flag_raise;
  logic [5:0]  out_flag_seq;
  logic [1:0]  out_alarm;

  int n_cmp;
  int n_bad;
  bit finished;

  logic [17:0] model_x [64];
  logic [85:0] expv;

  idx_exec_unit i_idx_exec_unit (.*);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [85:0] pack_out();
    return {out_done, out_mem_we, out_mem_wdata, out_jump, out_jump_target,
            out_e_load, out_e_right, out_dismiss, out_flag_raise, out_flag_seq, out_alarm};
  endfunction

  task automatic compare(input string tag);
    logic [85:0] act;
    act = pack_out();
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // behavioural reference: compute expected outputs and update model registers
  task automatic model_step(input int op, input int j, input int cfg, input int opnd,
                            input bit hold, input logic [35:0] mw, input bit flt, input int pc);
    logic [17:0] x, nx, o, p;
    bit wr, mwe, jmp, fr, dis;
    int alm;
    logic [35:0] wd;
    x = (j == 0) ? 18'd0 : model_x[j];
    o = 18'(opnd); p = 18'(pc);
    wr = 0; mwe = 0; jmp = 0; fr = 0; dis = 0; alm = 0; wd = 0; nx = 0;
    case (op)
      0: begin wr = 1; nx = mw[17:0]; end
      1: begin wr = 1; nx = 18'((int'(x) + int'(mw[17:0])) % 262144); end
      2: begin
        if (cfg == 0 || cfg == 8) begin wr = 1; nx = o; fr = (cfg == 8); end
        else if (cfg == 1) begin wr = 1; nx = 18'(262144 - int'(o)); end
        else alm = 1;
      end
      3: begin
        if (flt) alm = 2;
        else begin mwe = 1; wd = x[17] ? {18'h3FFFF, x} : {18'h0, x}; end
      end
      4, 5: begin
        int sv, sc;
        sv = x[17] ? int'(x) - 262144 : int'(x);
        sc = (cfg >= 16) ? cfg - 32 : cfg;
        jmp = (op == 4) ? (sv > 0) : (sv < 0);
        wr = 1;
        nx = 18'(sv + sc + 262144);
        dis = jmp && !hold;
      end
      default: ;
    endcase
    if (wr && j != 0) model_x[j] = nx;
    expv = {1'b1, mwe, wd, jmp, jmp ? o : 18'd0, jmp, jmp ? p : 18'd0, dis, fr,
            fr ? 6'(j) : 6'd0, 2'(alm)};
  endtask

  task automatic issue(input string tag, input int op, input int j, input int cfg,
                       input int opnd, input bit hold, input logic [35:0] mw,
                       input bit flt, input int pc);
    in_valid = 1'b1; in_op = 3'(op); in_idx = 6'(j); in_cfg = 5'(cfg);
    in_operand = 18'(opnd); in_hold = hold; in_mem_word = mw;
    in_mem_fault = flt; in_pc = 18'(pc);
    model_step(op, j, cfg, opnd, hold, mw, flt, pc);
    @(negedge clk);
    compare(tag);
    in_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    expv = '0;
    @(negedge clk);
    compare(tag);
  endtask

  // deposit j to read it back through the memory write port
  task automatic peek(input string tag, input int j);
    issue(tag, 3, j, 0, 0, 0, 36'd0, 0, 0);
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R8";
      4, 5: return "R10"; default: return "R1";
    endcase
  endfunction

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0;
    for (int k = 0; k < 64; k++) model_x[k] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_idx = '0; in_cfg = '0;
    in_operand = '0; in_hold = 1'b0; in_mem_word = '0; in_mem_fault = 1'b0; in_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle("R1");

    // R5 plain set, R8 read back
    issue("R5", 2, 1, 0, 'o000111, 0, 36'd0, 0, 0);
    peek("R8", 1);
    // R4 add with left half ignored
    issue("R4", 1, 1, 0, 0, 0, 36'o444000222010, 0, 0);
    peek("R4", 1);
    // R3 load positive and negative right halves
    issue("R3", 0, 2, 0, 0, 0, 36'o444333222111, 0, 0);
    peek("R3", 2);
    issue("R3", 0, 3, 0, 0, 0, 36'o454453777451, 0, 0);
    peek("R8", 3);
    // R5 negate
    issue("R5", 2, 4, 1, 5, 0, 36'd0, 0, 0);
    peek("R5", 4);
    // R6 flag raise
    issue("R6", 2, 5, 8, 7, 0, 36'd0, 0, 0);
    peek("R6", 5);
    // R7 unimplemented configurations leave the register
    issue("R7", 2, 1, 3, 'o777, 0, 36'd0, 0, 0);
    issue("R7", 2, 1, 31, 'o777, 0, 36'd0, 0, 0);
    peek("R7", 1);
    // R9 deposit fault, R13 no write
    issue("R9", 3, 2, 0, 0, 0, 36'd0, 1, 0);
    // R2 register zero
    issue("R2", 0, 0, 0, 0, 0, 36'o000000123456, 0, 0);
    issue("R2", 2, 0, 0, 'o5, 0, 36'd0, 0, 0);
    issue("R2", 1, 0, 0, 0, 0, 36'o000000000777, 0, 0);
    peek("R2", 0);
    // R10 R11 R12 jumps
    issue("R12", 5, 4, 1, 'o1234, 0, 36'd0, 0, 'o4321);
    peek("R11", 4);
    issue("R10", 4, 4, 31, 'o1234, 0, 36'd0, 0, 'o4321);
    peek("R11", 4);
    issue("R12", 4, 1, 0, 'o2000, 1, 36'd0, 0, 'o700);
    issue("R2", 2, 6, 0, 0, 0, 36'd0, 0, 0);
    issue("R10", 4, 6, 2, 'o55, 0, 36'd0, 0, 'o66);
    issue("R10", 5, 6, 0, 'o55, 0, 36'd0, 0, 'o66);
    issue("R10", 4, 6, 0, 'o55, 0, 36'd0, 0, 'o66);
    issue("R11", 4, 0, 3, 'o55, 0, 36'd0, 0, 'o66);
    issue("R11", 5, 0, 3, 'o55, 0, 36'd0, 0, 'o66);
    peek("R11", 0);
    // wrap-around
    issue("R4", 2, 7, 0, 'o377777, 0, 36'd0, 0, 0);
    issue("R4", 1, 7, 0, 0, 0, 36'o000000000001, 0, 0);
    peek("R4", 7);
    issue("R11", 2, 8, 1, 1, 0, 36'd0, 0, 0);
    issue("R11", 4, 8, 15, 0, 0, 36'd0, 0, 0);
    peek("R11", 8);
    // R1 spare codes
    issue("R1", 6, 3, 8, 'o77, 0, 36'o777777777777, 1, 'o11);
    issue("R1", 7, 3, 2, 'o77, 1, 36'o777777777777, 0, 'o11);
    idle("R1");

    // mixed back-to-back traffic
    for (int n = 0; n < 400; n++) begin
      int op, j, cfg, pick;
      op = int'($urandom_range(0, 7));
      j = int'($urandom_range(0, 7));
      pick = int'($urandom_range(0, 3));
      cfg = (op == 2 && pick == 0) ? 0 : (op == 2 && pick == 1) ? 1 :
            (op == 2 && pick == 2) ? 8 : int'($urandom_range(0, 31));
      issue(tag_of(op), op, j, cfg, int'($urandom_range(0, 262143)),
            bit'($urandom_range(0, 1)), {$urandom(), 4'($urandom())},
            ($urandom_range(0, 7) == 0), int'($urandom_range(0, 262143)));
      if ($urandom_range(0, 4) == 0) idle("R1");
    end
    for (int k = 0; k < 8; k++) peek("R3", k);
    idle("R1");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule